// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller with Isolation

This block is a physically tagged, direct-mapped cache controller for a small RISC core. It keeps two arrays, one for instruction fetches and one for data accesses. Each array has its own tag, valid and dirty state. A request carries a side flag, a read or write flag, a byte length and a physical address. A lookup that hits is served from the array. A lookup that misses first copies back the old line if that line is valid and dirty. It then fetches the new line over a word-wide request/acknowledge memory port, and the request completes after that.

Two status controls change how requests are routed. With swap set, instruction requests use the data array and data requests use the instruction array. With isolate set, data-side requests never reach memory: a miss is answered from whatever the line already holds, and a write clears the line's valid bit.

The controller keeps a sticky miss status bit. It reports a `direct` flag with each completion. A low `direct` means the requester still owes main memory a write, either as write-through or because the cache was bypassed. Accesses that are wider than 4 bytes, zero bytes long or marked uncached bypass the cache entirely.

Top module: `wt_cache`

## Requirements
- R1: A request whose length is 0 or greater than 4, or that is marked uncached, completes with `direct` low. It causes no memory-port traffic and leaves the miss status bit and the arrays unchanged.
- R2: The array used is the side flag (1 = data) XOR `stat_swap`. With swap set, a data read of a line that only the instruction side loaded hits without memory traffic, and the reverse holds too.
- R3: The line index is the address bits between the line offset and the cache size. The tag is the address bits above the cache size. A hit requires a set valid bit and an equal stored tag, and it completes with no memory traffic.
- R4: The miss status bit changes only when a data-side read completes. It then becomes 1 if that read missed and 0 if it hit. Instruction-side requests, writes and bypassed requests leave it unchanged. It is 0 after reset.
- R5: With `stat_isolate` set, a data-side request makes no memory traffic. A miss does not refill, and a read returns the bytes the line currently holds. Instruction-side requests are not affected by isolation.
- R6: A data-side write while isolated clears the valid bit of its line. A later non-isolated read of that address then misses and refills.
- R7: On a non-isolated miss, a valid and dirty line is first written back: LINE_WORDS word writes go to its old address, word 0 first. The new line is then read with LINE_WORDS word reads, word 0 first, and becomes valid and clean with the new tag.
- R8: A write sets the line's dirty bit only if at least one written byte differs from the stored byte.
- R9: `direct` is high at completion for reads and for isolated data-side accesses. It is low for non-isolated writes and for bypassed requests.
- R10: Byte i of an access (i < length) maps to line byte (address offset + i) mod LINE_BYTES, so an access wraps to word 0 of the same line. Read data is right-justified, with byte i in `rdata[8i+7:8i]` and the unused bytes zero. Write byte i is taken from `wdata[8i+7:8i]`.
- R11: `start` is a one-cycle pulse that is accepted only when the controller is idle. `ready` is a one-cycle pulse. `mem_req` stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| side_data | input | 1 | 1 = data side, 0 = instruction side |
| write | input | 1 | 1 = write, 0 = read |
| len | input | 4 | Access length in bytes |
| uncached | input | 1 | Request bypasses the cache |
| addr | input | 32 | Physical byte address |
| wdata | input | 32 | Write bytes, right-justified |
| stat_isolate | input | 1 | Isolate status control |
| stat_swap | input | 1 | Swap status control |
| ready | output | 1 | Completion pulse |
| rdata | output | 32 | Read bytes, right-justified |
| direct | output | 1 | Completed without a memory write owed |
| miss_flag | output | 1 | Miss status bit |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write-back word |
| mem_ack | input | 1 | Memory word acknowledge |
| mem_rdata | input | 32 | Refill word |

## Verification
The embedded properties check several rules on every cycle. The memory port stays silent for isolated and bypassed requests. A pending word request holds steady until it is acknowledged. The miss bit moves only at the end of a data read. A low `direct` only follows a bypass or a non-isolated write. A refill leaves its line valid and clean, and an isolated write leaves its line invalid. The directed scenarios cover the behaviours that no single-cycle property can show:
- byte wrap within a line;
- write-back holding the modified bytes at the old address;
- the absence of write-back after a write of unchanged bytes;
- swap routing;
- stale data returned by an isolated miss.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WBRD, S_WBXF, S_FILL, S_ACC, S_DONE
  } wtc_state_e;
endpackage

// File: rtl/wtc_lane_ram.sv
`timescale 1ns/1ps
module wtc_lane_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  // read-first single port, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/wtc_data_array.sv
`timescale 1ns/1ps
module wtc_data_array #(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic [3:0]          we,
  input  logic [3:0][AW-1:0]  addr,
  input  logic [3:0][7:0]     wdata,
  output logic [3:0][7:0]     rdata
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    wtc_lane_ram #(.AW(AW)) u_lane (
      .clk   (clk),
      .we    (we[l]),
      .addr  (addr[l]),
      .wdata (wdata[l]),
      .rdata (rdata[l])
    );
  end
endmodule

// File: rtl/wtc_tag_store.sv
`timescale 1ns/1ps
module wtc_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(NUM_LINES)-1:0] idx,
  input  logic                         fill_en,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic                         inval_en,
  input  logic                         dirty_en,
  output logic [TAG_W-1:0]             tag_o,
  output logic                         valid_o,
  output logic                         dirty_o
);
  logic [TAG_W-1:0]     tags [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q, dirty_q;

  always_ff @(posedge clk) begin
    if (fill_en) tags[idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (inval_en) begin
      valid_q[idx] <= 1'b0;
    end else if (dirty_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  assign tag_o   = tags[idx];
  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];

  // R7: a completed refill leaves the line valid and clean
  a_r7_fill_clean: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));
  // R6: an isolated write leaves its line invalid
  a_r6_inval: assert property (@(posedge clk) disable iff (rst)
    (inval_en && !fill_en) |=> !valid_q[$past(idx)]);
endmodule

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        side_data,
  input  logic        write,
  input  logic [3:0]  len,
  input  logic        uncached,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        stat_isolate,
  input  logic        stat_swap,
  output logic        ready,
  output logic [31:0] rdata,
  output logic        direct,
  output logic        miss_flag,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int CACHE_W    = OFF_W + IDX_W;
  localparam int TAG_W      = ADDR_W - CACHE_W;
  localparam int RAM_AW     = IDX_W + WSEL_W;

  wtc_state_e        st;
  logic              r_side, r_we, r_iso, r_phys, r_bypass, r_hit;
  logic [3:0]        r_len;
  logic [31:0]       r_addr, r_wdata;
  logic [WSEL_W-1:0] cnt;
  logic              ready_q, direct_q, miss_q;
  logic [31:0]       rdata_q;

  logic [1:0]            b0;
  logic [WSEL_W-1:0]     w0;
  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic [3:0]            lane_use, lane_we, lane_diff;
  logic [3:0][WSEL_W-1:0] lane_wsel;
  logic [3:0][7:0]       lane_wd, lane_wdata, dout_sel;
  logic [3:0][RAM_AW-1:0] lane_addr;
  logic [1:0][3:0][7:0]  dout_arr;
  logic [1:0][TAG_W-1:0] t_tag;
  logic [1:0]            t_valid, t_dirty;
  logic                  hit, fill_en, inval_en, dirty_en, last_word;
  logic [31:0]           rd_byte_vec;

  assign b0  = r_addr[1:0];
  assign w0  = r_addr[OFF_W-1:2];
  assign idx = r_addr[CACHE_W-1:OFF_W];
  assign tag = r_addr[ADDR_W-1:CACHE_W];
  assign last_word = (cnt == WSEL_W'(LINE_WORDS - 1));

  // byte lane routing with wrap inside the line
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      logic [1:0] rel;
      rel          = 2'(l) - b0;
      lane_use[l]  = ({2'b00, rel} < r_len);
      lane_wsel[l] = (2'(l) < b0) ? w0 + WSEL_W'(1) : w0;
      lane_wd[l]   = r_wdata[{rel, 3'b000} +: 8];
      lane_addr[l] = (st == S_ACC || st == S_DONE) ? {idx, lane_wsel[l]} : {idx, cnt};
      lane_wdata[l] = (st == S_FILL) ? mem_rdata[8*l +: 8] : lane_wd[l];
    end
  end

  assign dout_sel = dout_arr[r_phys];
  always_comb begin
    for (int l = 0; l < 4; l++) lane_diff[l] = lane_use[l] && (dout_sel[l] != lane_wd[l]);
    for (int i = 0; i < 4; i++)
      rd_byte_vec[8*i +: 8] = (4'(i) < r_len) ? dout_sel[b0 + 2'(i)] : 8'h00;
  end

  assign lane_we  = (st == S_FILL && mem_ack) ? 4'hF :
                    (st == S_DONE && r_we)    ? lane_use : 4'h0;
  assign fill_en  = (st == S_FILL) && mem_ack && last_word;
  assign inval_en = (st == S_DONE) && r_we && r_iso;
  assign dirty_en = (st == S_DONE) && r_we && !r_iso && (|lane_diff);
  assign hit      = t_valid[r_phys] && (t_tag[r_phys] == tag);

  for (genvar g = 0; g < 2; g++) begin : g_arr
    logic sel;
    assign sel = (r_phys == 1'(g));
    wtc_data_array #(.AW(RAM_AW)) u_data (
      .clk   (clk),
      .we    (lane_we & {4{sel}}),
      .addr  (lane_addr),
      .wdata (lane_wdata),
      .rdata (dout_arr[g])
    );
    wtc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst      (rst),
      .idx      (idx),
      .fill_en  (fill_en && sel),
      .fill_tag (tag),
      .inval_en (inval_en && sel),
      .dirty_en (dirty_en && sel),
      .tag_o    (t_tag[g]),
      .valid_o  (t_valid[g]),
      .dirty_o  (t_dirty[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ready_q  <= 1'b0;
      direct_q <= 1'b0;
      miss_q   <= 1'b0;
      rdata_q  <= '0;
      cnt      <= '0;
      r_side <= 1'b0; r_we <= 1'b0; r_iso <= 1'b0; r_phys <= 1'b0;
      r_bypass <= 1'b0; r_hit <= 1'b0; r_len <= '0; r_addr <= '0; r_wdata <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          r_side   <= side_data;
          r_we     <= write;
          r_len    <= len;
          r_addr   <= addr;
          r_wdata  <= wdata;
          r_iso    <= stat_isolate && side_data;
          r_phys   <= side_data ^ stat_swap;
          r_bypass <= uncached || (len == 4'd0) || (len > 4'd4);
          st       <= S_LOOK;
        end
        S_LOOK: begin
          r_hit <= hit;
          cnt   <= '0;
          if (r_bypass) begin
            ready_q  <= 1'b1;
            direct_q <= 1'b0;
            rdata_q  <= '0;
            st       <= S_IDLE;
          end else if (hit || r_iso) st <= S_ACC;
          else if (t_valid[r_phys] && t_dirty[r_phys]) st <= S_WBRD;
          else st <= S_FILL;
        end
        S_WBRD: st <= S_WBXF;
        S_WBXF: if (mem_ack) begin
          cnt <= last_word ? '0 : cnt + WSEL_W'(1);
          st  <= last_word ? S_FILL : S_WBRD;
        end
        S_FILL: if (mem_ack) begin
          cnt <= cnt + WSEL_W'(1);
          if (last_word) st <= S_ACC;
        end
        S_ACC: st <= S_DONE;
        S_DONE: begin
          ready_q  <= 1'b1;
          rdata_q  <= r_we ? 32'h0 : rd_byte_vec;
          direct_q <= !r_we || r_iso;
          if (r_side && !r_we) miss_q <= !r_hit;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_WBXF) || (st == S_FILL);
  assign mem_we    = (st == S_WBXF);
  assign mem_addr  = (st == S_WBXF) ? {t_tag[r_phys], idx, cnt, 2'b00} : {tag, idx, cnt, 2'b00};
  assign mem_wdata = dout_sel;
  assign ready     = ready_q;
  assign rdata     = rdata_q;
  assign direct    = direct_q;
  assign miss_flag = miss_q;

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r5_isolated_quiet: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !r_iso);
  a_r1_bypass_quiet: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !r_bypass);
  a_r4_miss_on_data_read: assert property (@(posedge clk) disable iff (rst)
    !$stable(miss_flag) |-> $past(st == S_DONE && r_side && !r_we));
  a_r9_direct_low: assert property (@(posedge clk) disable iff (rst)
    (ready && !direct) |-> (r_bypass || (r_we && !r_iso)));
endmodule

// File: tb/wt_cache_test.sv
`timescale 1ns/1ps
module wt_cache_test;
  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, side_data = 0, write = 0, uncached = 0, stat_isolate = 0, stat_swap = 0;
  logic [3:0] len = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic ready, direct, miss_flag, mem_req, mem_we, mem_ack;
  logic [31:0] rdata, mem_addr, mem_wdata, mem_rdata;
  int total = 0, bad = 0, rd_cnt, wr_cnt;
  logic [31:0] mem [1024];

  always #2.5 clk = ~clk;

  wt_cache uut (.*);

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3) ^ 8'(a >> 8);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < 1024; w++)
        mem[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      rd_cnt <= 0; wr_cnt <= 0; mem_ack <= 1'b0; mem_rdata <= '0;
    end else begin
      if (mem_req && mem_ack) begin
        if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
        else rd_cnt <= rd_cnt + 1;
      end
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  function automatic logic [7:0] mbyte(input int a);
    return mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  // expected line-wrapped read from current memory contents (16-byte lines)
  function automatic logic [31:0] exp_rd(input int a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mbyte((a & ~15) | ((a + i) & 15));
    return v;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  logic [31:0] o_rd; logic o_dir; int o_nr, o_nw;

  task automatic acc(input logic sd, input logic we, input logic [3:0] n, input logic unc,
                     input logic [31:0] a, input logic [31:0] wd);
    int r0, w0, k;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    side_data = sd; write = we; len = n; uncached = unc; addr = a; wdata = wd; start = 1;
    @(negedge clk);
    start = 0;
    k = 0;
    while (!ready && k < 300) begin @(negedge clk); k++; end
    if (k >= 300) chk(1'b0, "R11 timeout", 0, 1);
    o_rd = rdata; o_dir = direct; o_nr = rd_cnt - r0; o_nw = wr_cnt - w0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!ready && !mem_req, "R11 reset idle", {ready, mem_req}, 0);
    chk(miss_flag == 0, "R4 reset miss", miss_flag, 0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] e;
    e = exp_rd(32'h124, 4);
    acc(1, 0, 4, 0, 32'h124, 0);
    chk(o_rd == e, "R3 miss read data", o_rd, e);
    chk(o_nr == 4 && o_nw == 0, "R7 refill count", o_nr, 4);
    chk(miss_flag == 1, "R4 miss set", miss_flag, 1);
    chk(o_dir == 1, "R9 read direct", o_dir, 1);
    e = exp_rd(32'h126, 2);
    acc(1, 0, 2, 0, 32'h126, 0);
    chk(o_rd == e && o_nr == 0, "R3 hit read", o_rd, e);
    chk(miss_flag == 0, "R4 miss cleared", miss_flag, 0);
    e = exp_rd(32'h12E, 4);
    acc(1, 0, 4, 0, 32'h12E, 0);
    chk(o_rd == e && o_nr == 0, "R10 wrap read", o_rd, e);
  endtask

  task automatic t_write_same();
    logic [7:0] b = mbyte(32'h121);
    acc(1, 1, 1, 0, 32'h121, {24'h0, b});
    chk(o_dir == 0, "R9 write direct low", o_dir, 0);
    acc(1, 0, 4, 0, 32'h220, 0);
    chk(o_nw == 0 && o_nr == 4, "R8 clean no writeback", o_nw, 0);
  endtask

  task automatic t_write_back();
    acc(1, 0, 4, 0, 32'h120, 0);
    chk(o_nw == 0 && o_nr == 4, "R7 clean victim", o_nw, 0);
    acc(1, 1, 2, 0, 32'h12F, 32'h0000BEEF);
    acc(1, 0, 2, 0, 32'h12F, 0);
    chk(o_rd == 32'h0000BEEF && o_nr == 0, "R10 wrap write", o_rd, 32'h0000BEEF);
    acc(1, 0, 4, 0, 32'h220, 0);
    chk(o_nw == 4 && o_nr == 4, "R7 writeback count", o_nw, 4);
    chk(mbyte(32'h12F) == 8'hEF && mbyte(32'h120) == 8'hBE, "R7 writeback data",
        {mbyte(32'h120), mbyte(32'h12F)}, 16'hBEEF);
    chk(miss_flag == 1, "R4 miss after conflict", miss_flag, 1);
  endtask

  task automatic t_bypass();
    acc(1, 0, 8, 0, 32'h300, 0);
    chk(o_dir == 0 && o_nr == 0 && o_nw == 0, "R1 wide bypass", {o_dir, 8'(o_nr)}, 0);
    chk(miss_flag == 1, "R1 miss kept", miss_flag, 1);
    acc(1, 0, 4, 1, 32'h300, 0);
    chk(o_dir == 0 && o_nr == 0, "R1 uncached bypass", {o_dir, 8'(o_nr)}, 0);
    acc(1, 0, 4, 0, 32'h300, 0);
    chk(o_nr == 4, "R1 no line left by bypass", o_nr, 4);
  endtask

  task automatic t_instr_swap();
    logic [31:0] e;
    acc(1, 0, 4, 0, 32'h220, 0);
    chk(miss_flag == 0, "R4 data hit", miss_flag, 0);
    e = exp_rd(32'h400, 4);
    acc(0, 0, 4, 0, 32'h400, 0);
    chk(o_rd == e && o_nr == 4, "R2 instr refill", o_rd, e);
    chk(miss_flag == 0, "R4 instr leaves miss", miss_flag, 0);
    stat_swap = 1;
    acc(1, 0, 4, 0, 32'h400, 0);
    chk(o_rd == e && o_nr == 0, "R2 swap data uses instr array", o_nr, 0);
    acc(0, 0, 4, 0, 32'h220, 0);
    chk(o_nr == 0, "R2 swap instr uses data array", o_nr, 0);
    stat_swap = 0;
  endtask

  task automatic t_isolate();
    logic [31:0] e;
    stat_isolate = 1;
    e = exp_rd(32'h220, 4);
    acc(1, 0, 4, 0, 32'h520, 0);
    chk(o_nr == 0 && o_nw == 0, "R5 isolated miss quiet", o_nr, 0);
    chk(o_rd == e, "R5 stale data", o_rd, e);
    chk(o_dir == 1 && miss_flag == 1, "R9 isolated direct", {o_dir, miss_flag}, 2'b11);
    acc(1, 1, 4, 0, 32'h224, 32'h11223344);
    chk(o_dir == 1 && o_nr == 0 && o_nw == 0, "R6 isolated write quiet", o_dir, 1);
    acc(0, 0, 4, 0, 32'h440, 0);
    chk(o_nr == 4, "R5 instr not isolated", o_nr, 4);
    stat_isolate = 0;
    e = exp_rd(32'h224, 4);
    acc(1, 0, 4, 0, 32'h224, 0);
    chk(o_nr == 4 && o_nw == 0, "R6 line invalidated", o_nr, 4);
    chk(o_rd == e, "R6 refilled data", o_rd, e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_write_same();
    t_write_back();
    t_bypass();
    t_instr_swap();
    t_isolate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL R11 watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule